// File: doc/BRIEF.md
# Transposed-Bitmap Content-Addressable Memory

This block is a small content-addressable memory. It holds a fixed number of entries, and each entry stores one key. The storage is a single bit array that is read and written in two different shapes. Updates write one bit at a time. Lookups read a whole row, and that row is the match vector for one key value. The array is kept transposed: the key selects the row and the entry number selects the column bit. A search is therefore one synchronous read. The cost is that replacing an entry's key takes two bit writes, one to clear the old key's bit and one to set the new key's bit.

A client starts an update by raising `wr_req` with an entry number and a key while `wr_busy` is low. The block then spends two cycles on the update. In the first it erases the entry's old bit, which it skips if the entry has never been written. In the second it sets the new bit. While `wr_busy` is high, further requests are dropped. Lookups are independent of updates. When `lk_en` is high, `lk_key` is sampled, and on the next clock the block returns the hit vector, the lowest hitting entry number and a hit flag.

Top module: `bitmap_cam`

## Requirements
- R1: After reset, `wr_busy` is 0, `match_vec` is 0 and `match_hit` is 0, and no key matches any entry until that entry is written.
- R2: A lookup with `lk_en`=1 on key k yields, one clock later, `match_vec` bit i = 1 exactly when entry i has been written and its most recent key is k.
- R3: A request with `wr_req`=1 while `wr_busy`=0 is accepted at that clock edge. `wr_busy` is then 1 for exactly the two following cycles and 0 afterwards.
- R4: A request raised while `wr_busy`=1 is ignored: the stored contents are left unchanged and no extra busy cycles follow.
- R5: Rewriting an entry with a different key removes its match on the old key and adds its match on the new key.
- R6: Several entries holding the same key all report a hit on that key in the same vector.
- R7: `match_idx` is the lowest set bit position of `match_vec` and `match_hit` is 1 exactly when `match_vec` is non-zero. `match_idx` is 0 when there is no hit.
- R8: `lk_clr`=1 forces `match_vec` to 0 on the next clock, and it overrides `lk_en`.
- R9: With `lk_en`=0 and `lk_clr`=0, `match_vec` holds its value whatever `lk_key` does.
- R10: A lookup sampled on the same clock edge as an update's set-bit write returns the array without that bit. The old-key erase, made one cycle earlier, is already visible. A lookup one cycle later sees the new bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for update and lookup sides |
| rst_n | input | 1 | Active-low synchronous reset; clears the array, the entry state and the result |
| wr_req | input | 1 | Update request, taken when `wr_busy` is low |
| wr_idx | input | 4 | Entry number to update |
| wr_key | input | 8 | New key for that entry |
| wr_busy | output | 1 | High during the two update cycles |
| lk_en | input | 1 | Lookup enable; samples `lk_key` |
| lk_clr | input | 1 | Synchronous clear of the match result |
| lk_key | input | 8 | Search key |
| match_vec | output | 16 | Hit vector, bit i for entry i |
| match_idx | output | 4 | Lowest hitting entry number |
| match_hit | output | 1 | Any entry hit |

## Verification
A lookup's vector, index and flag are all due on the clock after `lk_key` is sampled. The bench drives every input on a falling edge and reads all three results on the next falling edge. An update occupies the two cycles after acceptance. The bench samples `wr_busy` on each of the three falling edges that follow the request, and it starts the next lookup only after busy drops. The only exception is the R10 case. There the lookup is placed deliberately on the set-bit cycle, and its expected vector is the pre-update contents with the entry's bit cleared.

// File: rtl/bitmap_cam_pkg.sv
package bitmap_cam_pkg;

    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_ERASE = 2'd1,
        UPD_SET   = 2'd2
    } upd_state_e;

endpackage

// File: rtl/bcam_bit_array.sv
module bcam_bit_array #(
    parameter int COLS   = 16,
    parameter int ROW_AW = 8,
    localparam int COL_AW = $clog2(COLS),
    localparam int BIT_AW = ROW_AW + COL_AW,
    localparam int ROWS   = 1 << ROW_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bw_en,
    input  logic [BIT_AW-1:0] bw_addr,
    input  logic              bw_val,
    input  logic              rd_en,
    input  logic              rd_clr,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [COLS-1:0]   rd_word
);

    logic [COLS-1:0] rows_q [ROWS];
    logic [COLS-1:0] word_d, word_q;

    // narrow update view: row = upper address bits, column = lower bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                rows_q[r] <= '0;
            end
        end else if (bw_en) begin
            rows_q[bw_addr[BIT_AW-1:COL_AW]][bw_addr[COL_AW-1:0]] <= bw_val;
        end
    end

    always_comb begin
        word_d = word_q;
        if (rd_clr) begin
            word_d = '0;
        end else if (rd_en) begin
            word_d = rows_q[rd_row];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign rd_word = word_q;

endmodule

// File: rtl/bcam_updater.sv
module bcam_updater
    import bitmap_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BIT_AW = KEY_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [KEY_W-1:0]  req_key,
    output logic              busy,
    output logic              bw_en,
    output logic [BIT_AW-1:0] bw_addr,
    output logic              bw_val
);

    typedef struct packed {
        upd_state_e                     st;
        logic [IDX_W-1:0]               idx;
        logic [KEY_W-1:0]               key;
        logic [ENTRIES-1:0][KEY_W-1:0]  keys;
        logic [ENTRIES-1:0]             valid;
    } upd_t;

    upd_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        bw_en   = 1'b0;
        bw_addr = '0;
        bw_val  = 1'b0;
        unique case (s_q.st)
            UPD_IDLE: begin
                if (req) begin
                    s_d.st  = UPD_ERASE;
                    s_d.idx = req_idx;
                    s_d.key = req_key;
                end
            end
            UPD_ERASE: begin
                // clear the old key's bit only if the entry was ever written
                bw_en   = s_q.valid[s_q.idx];
                bw_addr = {s_q.keys[s_q.idx], s_q.idx};
                bw_val  = 1'b0;
                s_d.st  = UPD_SET;
            end
            UPD_SET: begin
                bw_en              = 1'b1;
                bw_addr            = {s_q.key, s_q.idx};
                bw_val             = 1'b1;
                s_d.keys[s_q.idx]  = s_q.key;
                s_d.valid[s_q.idx] = 1'b1;
                s_d.st             = UPD_IDLE;
            end
            default: s_d.st = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != UPD_IDLE);

endmodule

// File: rtl/bcam_lowest_enc.sv
module bcam_lowest_enc #(
    parameter int WIDTH  = 16,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        for (int b = WIDTH - 1; b >= 0; b--) begin
            if (vec[b]) begin
                idx = IDX_W'(b);
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/bitmap_cam.sv
module bitmap_cam #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BIT_AW = KEY_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [KEY_W-1:0]   wr_key,
    output logic               wr_busy,
    input  logic               lk_en,
    input  logic               lk_clr,
    input  logic [KEY_W-1:0]   lk_key,
    output logic [ENTRIES-1:0] match_vec,
    output logic [IDX_W-1:0]   match_idx,
    output logic               match_hit
);

    logic              bw_en;
    logic [BIT_AW-1:0] bw_addr;
    logic              bw_val;

    bcam_updater #(
        .ENTRIES (ENTRIES),
        .KEY_W   (KEY_W)
    ) u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (wr_req),
        .req_idx (wr_idx),
        .req_key (wr_key),
        .busy    (wr_busy),
        .bw_en   (bw_en),
        .bw_addr (bw_addr),
        .bw_val  (bw_val)
    );

    bcam_bit_array #(
        .COLS   (ENTRIES),
        .ROW_AW (KEY_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bw_en   (bw_en),
        .bw_addr (bw_addr),
        .bw_val  (bw_val),
        .rd_en   (lk_en),
        .rd_clr  (lk_clr),
        .rd_row  (lk_key),
        .rd_word (match_vec)
    );

    bcam_lowest_enc #(
        .WIDTH (ENTRIES)
    ) u_enc (
        .vec (match_vec),
        .idx (match_idx),
        .any (match_hit)
    );

endmodule

// File: rtl/bitmap_cam_chk.sv
module bitmap_cam_chk #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_req,
    input logic               wr_busy,
    input logic               lk_en,
    input logic               lk_clr,
    input logic [ENTRIES-1:0] match_vec,
    input logic [IDX_W-1:0]   match_idx,
    input logic               match_hit
);

    logic [ENTRIES-1:0] below_idx;
    always_comb begin
        below_idx = '0;
        for (int b = 0; b < ENTRIES; b++) begin
            below_idx[b] = (IDX_W'(b) < match_idx);
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (match_vec == '0 && !wr_busy));

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_busy) |=> wr_busy);

    p_busy_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |=> wr_busy);

    p_busy_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && $past(wr_busy)) |=> !wr_busy);

    p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |-> (match_vec[match_idx] && (match_vec & below_idx) == '0));

    p_any_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec != '0) |-> match_hit);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_clr |=> (match_vec == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_en && !lk_clr) |=> $stable(match_vec));

endmodule

bind bitmap_cam bitmap_cam_chk #(
    .ENTRIES (ENTRIES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_busy   (wr_busy),
    .lk_en     (lk_en),
    .lk_clr    (lk_clr),
    .match_vec (match_vec),
    .match_idx (match_idx),
    .match_hit (match_hit)
);

// File: tb/bitmap_cam_tb.sv
module bitmap_cam_tb;

    localparam int N  = 16;
    localparam int KW = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_key = '0;
    logic          wr_busy;
    logic          lk_en = 1'b0;
    logic          lk_clr = 1'b0;
    logic [KW-1:0] lk_key = '0;
    logic [N-1:0]  match_vec;
    logic [IW-1:0] match_idx;
    logic          match_hit;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [KW-1:0] m_key [N];
    logic [N-1:0]  m_val;

    always #10 clk = ~clk;

    bitmap_cam u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_idx(wr_idx), .wr_key(wr_key),
        .wr_busy(wr_busy), .lk_en(lk_en), .lk_clr(lk_clr), .lk_key(lk_key),
        .match_vec(match_vec), .match_idx(match_idx), .match_hit(match_hit)
    );

    function automatic logic [N-1:0] exp_vec(input logic [KW-1:0] k);
        logic [N-1:0] v = '0;
        for (int i = 0; i < N; i++) v[i] = m_val[i] && (m_key[i] == k);
        return v;
    endfunction

    function automatic logic [IW-1:0] exp_low(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return IW'(i);
        return '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_result(input string req, input logic [N-1:0] ev);
        chk(req, 32'(match_vec), 32'(ev));
        chk({req, "/R7 idx"}, 32'(match_idx), 32'(exp_low(ev)));
        chk({req, "/R7 hit"}, 32'(match_hit), 32'(ev != '0));
    endtask

    // inputs change at negedge; results read one negedge later
    task automatic lookup(input string req, input logic [KW-1:0] k);
        lk_key = k;
        lk_en  = 1'b1;
        @(negedge clk);
        lk_en  = 1'b0;
        check_result(req, exp_vec(k));
    endtask

    // mode 0 plain, 1 intruding request while busy (R4), 2 overlapping lookup (R10)
    task automatic do_write(input logic [IW-1:0] i, input logic [KW-1:0] k, input int mode);
        logic [N-1:0] ev;
        while (wr_busy) @(negedge clk);
        wr_req = 1'b1; wr_idx = i; wr_key = k;
        @(negedge clk);
        chk("R3 busy first cycle", 32'(wr_busy), 1);
        if (mode == 1) begin
            wr_idx = i ^ 4'h1; wr_key = k ^ 8'h80;
        end else begin
            wr_req = 1'b0;
        end
        @(negedge clk);
        chk("R3 busy second cycle", 32'(wr_busy), 1);
        if (mode == 2) begin
            ev = exp_vec(k);
            ev[i] = 1'b0;
            lk_key = k; lk_en = 1'b1;
        end
        wr_req = 1'b0;
        @(negedge clk);
        if (mode == 2) begin
            lk_en = 1'b0;
            check_result("R10 overlap lookup", ev);
        end
        chk(mode == 1 ? "R4 no extra busy" : "R3 busy released", 32'(wr_busy), 0);
        m_key[i] = k;
        m_val[i] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [KW-1:0] k0;
        logic [N-1:0]  held;
        void'($urandom(32'h5eed_0c4a));
        m_val = '0;
        for (int i = 0; i < N; i++) m_key[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy after reset", 32'(wr_busy), 0);
        chk("R1 vec after reset", 32'(match_vec), 0);
        chk("R1 hit after reset", 32'(match_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        lookup("R1 empty key 00", 8'h00);
        lookup("R1 empty key ff", 8'hff);

        // corner addresses and a shared key
        do_write(4'd0, 8'h00, 0);
        do_write(4'd15, 8'hff, 0);
        lookup("R2 entry0 key00", 8'h00);
        lookup("R2 entry15 keyff", 8'hff);
        do_write(4'd9, 8'h42, 0);
        do_write(4'd5, 8'h42, 0);
        do_write(4'd3, 8'h42, 0);
        lookup("R6 shared key", 8'h42);
        // rewrite entry 3: old key loses it
        do_write(4'd3, 8'h17, 0);
        lookup("R5 old key erased", 8'h42);
        lookup("R5 new key present", 8'h17);
        // same key rewritten to same entry
        do_write(4'd5, 8'h42, 0);
        lookup("R5 same key rewrite", 8'h42);
        // ignored request while busy
        do_write(4'd6, 8'h21, 1);
        lookup("R4 intruder key absent", 8'ha1);
        lookup("R4 target present", 8'h21);
        // overlapped lookup on the set-bit cycle, then visible
        do_write(4'd7, 8'h42, 2);
        lookup("R10 next cycle sees bit", 8'h42);
        do_write(4'd9, 8'h17, 2);
        lookup("R10 moved entry visible", 8'h17);

        // hold and clear
        lookup("R9 load", 8'h42);
        held = match_vec;
        lk_key = 8'h17;
        @(negedge clk);
        chk("R9 hold with enable low", 32'(match_vec), 32'(held));
        lk_clr = 1'b1; lk_en = 1'b1; lk_key = 8'h42;
        @(negedge clk);
        lk_clr = 1'b0; lk_en = 1'b0;
        check_result("R8 clear over enable", '0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            k0 = ($urandom % 2 == 0) ? KW'($urandom % 6) : KW'($urandom);
            if ($urandom % 3 == 0) begin
                do_write(IW'($urandom), k0, int'($urandom % 3));
            end else begin
                lookup("R2 random lookup", k0);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule